// File: doc/BRIEF.md
# Serial configuration register bank with frame-aligned hold

This block is the configuration store of a picture-in-picture controller. A host writes it over a two-wire serial bus in slave mode. Each transfer carries the device address, a start subaddress and then any number of data bytes. The block moves the subaddress on by one after each byte, so a burst fills consecutive registers. Every register byte is presented in parallel on one wide output bus, with byte `k` at bits `[8k+7:8k]`.

The bytes that shape the visible picture are double buffered. These are the inset enables, the mode, the size ratios, the positions, the border widths and the colour and priority selects. A bus write lands in a shadow copy only. The effective copy picks the shadow up on the rising edge of the main vertical sync, so a picture change never tears mid-frame. A hold flag, bit 7 of register 10h, blocks those copies. The host can therefore stage a whole set of changes and release them together at the first vertical sync after it clears the flag. All other fields, including the hold flag itself, take effect as soon as the byte is acknowledged.

Top module: `pip_cfg_i2c`

## Requirements
- R1: A transfer whose address byte is not 2Ch (7-bit address 16h, write) receives no acknowledge, and no register changes.
- R2: After an acknowledged subaddress, successive data bytes are stored at successive subaddresses, and each one is acknowledged.
- R3: A subaddress above 18h is not acknowledged, whether it is sent directly or reached by incrementing. No register changes.
- R4: Data bytes sent to subaddresses 15h to 18h are acknowledged and then discarded.
- R5: Bits that have no function always read as zero, whatever is written. These are all of registers 06h and 07h, bit 3 of 0Eh, bits 7:6 of 0Fh, and bits 7 and 3 of 14h.
- R6: After reset, every register output is zero except register 14h, which is 22h. That value means a 4-pixel horizontal border and a 2-line vertical border.
- R7: Protected bits change only in the cycle after a commit. A commit is a single-cycle pulse raised by a rising edge on `vsync_i`. The protected bits are:
  - register 00h bits 7:6 and 3:0;
  - registers 01h to 05h, 11h and 12h in full;
  - register 0Dh bits 7, 6 and 3;
  - register 0Eh bits 7:4 and 2:0;
  - register 10h bits 5:0;
  - register 14h bits 6:4 and 2:0.
- R8: While register 10h bit 7 is 1, vertical sync edges cause no commit. After that bit is written to 0, protected fields take their pending values at the next vertical sync edge.
- R9: Unprotected bits show the written value as soon as the byte is acknowledged, without any vertical sync.
- R10: An address byte 2Dh (read direction) is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the wire, asynchronous |
| vsync_i | input | 1 | Main vertical sync, asynchronous, active high |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| regs_o | output | 168 | Effective register bytes 00h to 14h, byte k at [8k+7:8k] |

## Verification
A table of single-byte writes to unprotected registers checks that the value appears at once. Entries that aim at unused bits separate "stored" from "masked". Multi-byte bursts are sent from three start points: one well inside the map, one that runs into the reserved range, and one that runs past 18h. Together they tell apart correct incrementing, acknowledged discards and refused bytes. Protected writes are observed before and after a vertical sync edge, with and without the hold flag set. This separates immediate, frame-aligned and held behaviour. Foreign and read-direction addresses confirm that the slave stays silent.

// File: rtl/pip_cfg_pkg.sv
package pip_cfg_pkg;

  localparam int HOLD_REG = 16;
  localparam int HOLD_BIT = 7;

  // Bits that carry a function; all others are forced to zero on write.
  function automatic logic [7:0] used_mask(input int idx);
    case (idx)
      6, 7:    used_mask = 8'h00;
      14:      used_mask = 8'hF7;
      15:      used_mask = 8'h3F;
      20:      used_mask = 8'h77;
      default: used_mask = 8'hFF;
    endcase
  endfunction

  // Bits whose effective value follows the shadow only at a commit.
  function automatic logic [7:0] prot_mask(input int idx);
    case (idx)
      0:                      prot_mask = 8'hCF;
      1, 2, 3, 4, 5, 17, 18:  prot_mask = 8'hFF;
      13:                     prot_mask = 8'hC8;
      14:                     prot_mask = 8'hF7;
      16:                     prot_mask = 8'h3F;
      20:                     prot_mask = 8'h77;
      default:                prot_mask = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reset_val(input int idx);
    reset_val = (idx == 20) ? 8'h22 : 8'h00;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK, ST_DATA, ST_DATA_ACK
  } rx_state_t;

endpackage

// File: rtl/pip_sync.sv
module pip_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pip_i2c_rx.sv
module pip_i2c_rx
  import pip_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h16,
  parameter logic [7:0] SUB_LAST = 8'h18,
  parameter int         NREG     = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);
  localparam logic [7:0] ADDR_WR   = {DEV_ADDR, 1'b0};
  localparam logic [7:0] STORE_END = 8'(NREG);

  rx_state_t   state_q, state_d;
  logic [3:0]  cnt_q, cnt_d;
  logic [7:0]  sh_q, sh_d, ptr_q, ptr_d, wa_q, wa_d, wd_q, wd_d;
  logic        oe_q, oe_d, wr_q, wr_d, scl_p, sda_p;
  logic        scl_rise, scl_fall, start_c, stop_c;

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  always_comb begin
    state_d = state_q; cnt_d = cnt_q; sh_d = sh_q; ptr_d = ptr_q;
    oe_d = oe_q; wr_d = 1'b0; wa_d = wa_q; wd_d = wd_q;
    if (start_c) begin
      state_d = ST_ADDR; cnt_d = '0; oe_d = 1'b0;
    end else if (stop_c) begin
      state_d = ST_IDLE; oe_d = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_SUB, ST_DATA: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q == ADDR_WR) begin oe_d = 1'b1; state_d = ST_ADDR_ACK; end
              else state_d = ST_IDLE;
            end else if (state_q == ST_SUB) begin
              if (sh_q <= SUB_LAST) begin
                oe_d = 1'b1; ptr_d = sh_q; state_d = ST_SUB_ACK;
              end else state_d = ST_IDLE;
            end else begin
              if (ptr_q <= SUB_LAST) begin
                oe_d = 1'b1; ptr_d = ptr_q + 8'd1; state_d = ST_DATA_ACK;
                wr_d = (ptr_q < STORE_END); wa_d = ptr_q; wd_d = sh_q;
              end else state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin oe_d = 1'b0; state_d = ST_SUB; end
        ST_SUB_ACK, ST_DATA_ACK: if (scl_fall) begin oe_d = 1'b0; state_d = ST_DATA; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; ptr_q <= '0;
      oe_q <= 1'b0; wr_q <= 1'b0; wa_q <= '0; wd_q <= '0;
      scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      state_q <= state_d; cnt_q <= cnt_d; sh_q <= sh_d; ptr_q <= ptr_d;
      oe_q <= oe_d; wr_q <= wr_d; wa_q <= wa_d; wd_q <= wd_d;
      scl_p <= scl_s; sda_p <= sda_s;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = wr_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
endmodule

// File: rtl/pip_cfg_regs.sv
module pip_cfg_regs
  import pip_cfg_pkg::*;
#(
  parameter int NREG = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            vsync_s,
  output logic [NREG*8-1:0] regs_o,
  output logic            commit_o
);
  logic [7:0] shadow_q [NREG];
  logic [7:0] active_q [NREG];
  logic       vs_p, commit_q, commit_d, hold;

  assign hold     = shadow_q[HOLD_REG][HOLD_BIT];
  assign commit_d = vsync_s & ~vs_p & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin vs_p <= 1'b0; commit_q <= 1'b0; end
    else        begin vs_p <= vsync_s; commit_q <= commit_d; end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] UM = used_mask(i);
    localparam logic [7:0] PM = prot_mask(i);
    localparam logic [7:0] RV = reset_val(i);
    logic [7:0] shadow_d, active_d;

    always_comb begin
      shadow_d = (wr_en && wr_addr == 8'(i)) ? (wr_data & UM) : shadow_q[i];
      active_d = commit_q ? shadow_q[i] : active_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin shadow_q[i] <= RV; active_q[i] <= RV; end
      else        begin shadow_q[i] <= shadow_d; active_q[i] <= active_d; end
    end

    assign regs_o[i*8 +: 8] = (shadow_q[i] & ~PM) | (active_q[i] & PM);
  end

  assign commit_o = commit_q;
endmodule

// File: rtl/pip_cfg_i2c.sv
module pip_cfg_i2c
  import pip_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h16,
  parameter logic [7:0] SUB_LAST  = 8'h18,
  parameter int         NREG      = 21,
  parameter int         SYNC_LEN  = 2,
  localparam int        REG_W     = NREG * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             vsync_i,
  output logic             sda_oe_o,
  output logic [REG_W-1:0] regs_o
);
  logic       scl_s, sda_s, vsync_s, wr_en, commit;
  logic [7:0] wr_addr, wr_data;

  pip_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
  pip_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));
  pip_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_vs_sync (
    .clk(clk), .rst_n(rst_n), .d_i(vsync_i), .q_o(vsync_s));

  pip_i2c_rx #(.DEV_ADDR(DEV_ADDR), .SUB_LAST(SUB_LAST), .NREG(NREG)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .sda_oe(sda_oe_o),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  pip_cfg_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vsync_s(vsync_s), .regs_o(regs_o), .commit_o(commit));
endmodule

// File: rtl/pip_cfg_i2c_chk.sv
module pip_cfg_i2c_chk
  import pip_cfg_pkg::*;
#(
  parameter int NREG = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NREG*8-1:0] regs_o,
  input logic              commit,
  input logic              wr_en,
  input logic [7:0]        wr_addr
);
  logic [NREG*8-1:0] pm, um;
  logic              hold;

  for (genvar i = 0; i < NREG; i++) begin : g_m
    assign pm[i*8 +: 8] = prot_mask(i);
    assign um[i*8 +: 8] = used_mask(i);
  end
  assign hold = regs_o[HOLD_REG*8 + HOLD_BIT];

  a_r7_prot_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(regs_o & pm));
  a_r9_unprot_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o & ~pm));
  a_r5_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o & ~um) == '0);
  a_r8_hold_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> !commit);
  a_r7_commit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  a_r4_write_in_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < 8'(NREG)));
endmodule

bind pip_cfg_i2c pip_cfg_i2c_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .regs_o(regs_o), .commit(commit),
  .wr_en(wr_en), .wr_addr(wr_addr));

// File: tb/pip_cfg_i2c_bench.sv
module pip_cfg_i2c_bench;
  localparam int NREG = 21;
  localparam int Q    = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, vsync = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] regs, snap, exp_rst;
  wire  sda_line = sda_m & ~sda_oe;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  pip_cfg_i2c u_pip_cfg_i2c (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .vsync_i(vsync), .sda_oe_o(sda_oe), .regs_o(regs));

  // sub, written data, expected byte
  localparam logic [23:0] VEC [9] = '{
    24'h08A5A5, 24'h093C3C, 24'h0AFFFF, 24'h0B1212, 24'h0C8080,
    24'h0FFF3F, 24'h13C3C3, 24'h06FF00, 24'h075A00 };

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic chkv(input string tag, input logic [NREG*8-1:0] act, input logic [NREG*8-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] rb(input int idx);
    rb = regs[idx*8 +: 8];
  endfunction

  task automatic bstart;
    sda_m = 1'b1; scl = 1'b1; waitq(Q);
    sda_m = 1'b0; waitq(Q);
    scl = 1'b0; waitq(Q);
  endtask

  task automatic bstop;
    sda_m = 1'b0; waitq(Q);
    scl = 1'b1; waitq(Q);
    sda_m = 1'b1; waitq(2*Q);
  endtask

  task automatic sbyte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; waitq(Q);
      scl = 1'b1; waitq(2*Q);
      scl = 1'b0; waitq(Q);
    end
    sda_m = 1'b1; waitq(Q);
    scl = 1'b1; waitq(Q);
    ack = ~sda_line; waitq(Q);
    scl = 1'b0; waitq(Q);
  endtask

  // acks[0]=address, [1]=subaddress, [2+k]=data byte k; data sent from d[31:24]
  task automatic xfer(input logic [7:0] a8, input logic [7:0] sub, input int n,
                      input logic [31:0] d, output logic [5:0] acks);
    logic a;
    acks = '0;
    bstart;
    sbyte(a8, a);  acks[0] = a;
    sbyte(sub, a); acks[1] = a;
    for (int k = 0; k < n; k++) begin
      sbyte(d[31-8*k -: 8], a); acks[2+k] = a;
    end
    bstop;
  endtask

  task automatic vs_pulse;
    vsync = 1'b1; waitq(8);
    vsync = 1'b0; waitq(4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] ak;
    exp_rst = '0; exp_rst[20*8 +: 8] = 8'h22;
    waitq(5); rst_n = 1'b1; waitq(5);
    chkv("R6 reset values", regs, exp_rst);

    for (int v = 0; v < 9; v++) begin
      xfer(8'h2C, VEC[v][23:16], 1, {VEC[v][15:8], 24'h0}, ak);
      chk((VEC[v][15:8] != VEC[v][7:0]) ? "R5 unused bits" : "R9 immediate",
          {24'h0, rb(int'(VEC[v][23:16]))}, {24'h0, VEC[v][7:0]});
    end

    xfer(8'h2C, 8'h0B, 3, 32'h11223300, ak);
    chk("R2 burst acks", {26'h0, ak}, 32'h1F);
    chk("R2 burst bytes", {8'h0, rb(11), rb(12), rb(13)}, 32'h00112233);

    snap = regs;
    xfer(8'h58, 8'h08, 1, 32'h0, ak);
    chk("R1 foreign address ack", {31'h0, ak[0]}, 32'h0);
    chkv("R1 no change", regs, snap);
    xfer(8'h2D, 8'h08, 1, 32'h0, ak);
    chk("R10 read direction ack", {31'h0, ak[0]}, 32'h0);
    xfer(8'h2C, 8'h19, 1, 32'h77000000, ak);
    chk("R3 subaddress 19h ack", {30'h0, ak[1:0]}, 32'h1);
    chkv("R3 no change", regs, snap);
    xfer(8'h2C, 8'h17, 3, 32'hAABBCC00, ak);
    chk("R4 R3 reserved burst acks", {26'h0, ak}, 32'h0F);
    chkv("R4 reserved discarded", regs, snap);

    xfer(8'h2C, 8'h00, 1, 32'hFF000000, ak);
    chk("R9 reg00 open bits", {24'h0, rb(0)}, 32'h30);
    vs_pulse;
    chk("R7 reg00 after vsync", {24'h0, rb(0)}, 32'hFF);

    xfer(8'h2C, 8'h14, 2, 32'h55990000, ak);
    chk("R4 reserved byte acked", {31'h0, ak[3]}, 32'h1);
    chk("R7 reg14 pending", {24'h0, rb(20)}, 32'h22);
    xfer(8'h2C, 8'h01, 1, 32'h77000000, ak);
    chk("R7 reg01 pending", {24'h0, rb(1)}, 32'h0);
    vs_pulse;
    chk("R7 reg01 committed", {24'h0, rb(1)}, 32'h77);
    chk("R7 reg14 committed", {24'h0, rb(20)}, 32'h55);

    xfer(8'h2C, 8'h10, 1, 32'h80000000, ak);
    chk("R9 hold flag visible", {24'h0, rb(16)}, 32'h80);
    xfer(8'h2C, 8'h02, 1, 32'h44000000, ak);
    vs_pulse;
    chk("R8 held across vsync", {24'h0, rb(2)}, 32'h0);
    xfer(8'h2C, 8'h10, 1, 32'h00000000, ak);
    chk("R8 released waits for vsync", {24'h0, rb(2)}, 32'h0);
    vs_pulse;
    chk("R8 applied at vsync", {24'h0, rb(2)}, 32'h44);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule